// File: doc/BRIEF.md
# Shaped Volume Envelope Generator

This block produces a 5-bit volume level that walks through a 32-step ramp at a rate set by a 16-bit period, following one of several contours chosen by a 4-bit shape value. The available contours are:

- a one-shot fall or rise that finishes at zero;
- a repeating sawtooth, either rising or falling;
- a repeating triangle;
- a ramp that ends and then stays at full scale.

Any sound channel that selects the envelope as its volume source uses the level index. The volume table that turns the index into an amplitude is not part of this block, and neither are the tone, noise and mixing stages.

Software loads the period one byte at a time, through a low-byte strobe and a high-byte strobe, and writes the shape through a third strobe. A write to the shape restarts the envelope. A prescaled tick enable advances the internal period counter. Each time that counter expires, the level moves one step unless the envelope has frozen.

Top module: `env_gen`

## Requirements
- R1: The period P is `{high byte, low byte}`, written through `coarse_we` and `fine_we` from `wr_data`. For P ≥ 1, each envelope step lasts 2·P ticks.
- R2: With P = 0, the envelope steps on every tick, which is twice the rate of P = 1.
- R3: The shape is `wr_data[3:0]`, with bit 3 continue, bit 2 attack, bit 1 alternate and bit 0 hold. The output level is the step counter XOR 31 when attack is set, and the step counter unchanged when attack is clear. The level therefore rises when attack is set and falls when it is clear.
- R4: A shape write restarts the envelope, even when it writes the value already held. A restart sets the step counter to 31, clears the frozen state and zeroes the period counter. A restart takes priority over a tick in the same cycle, so the level just after a shape write is 31 (attack clear) or 0 (attack set).
- R5: Each period expiry decrements the step counter by one, so one ramp covers 32 steps, from counter value 31 down to 0.
- R6: When the counter moves past 0 and the effective hold flag is set, the level freezes. With alternate also set, the frozen level is 31 minus the final ramp level.
- R7: When the counter moves past 0 and hold is clear, the counter reloads to 31. If alternate is also set, the direction reverses, giving a triangle. If alternate is clear, the result is a sawtooth.
- R8: With continue clear, the envelope acts as if hold were 1 and alternate equalled attack. It therefore always ends frozen at level 0.
- R9: After reset the period is 0, the shape is 0 and the level is 31.
- R10: A period write does not reset the period counter. On the next tick, the envelope steps if the count has reached the new step length.
- R11: When no tick arrives, the level and the period counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled step enable |
| fine_we | input | 1 | Load the low period byte from wr_data |
| coarse_we | input | 1 | Load the high period byte from wr_data |
| shape_we | input | 1 | Load the shape from wr_data[3:0] and restart |
| wr_data | input | 8 | Write data |
| level | output | 5 | Current envelope level index |

## Verification
A wrong step counter or direction mask shows up on `level` at the first expiry after the fault, so with a short period it appears within a few ticks. A wrong frozen state shows up as a level that keeps moving after the end of a ramp, or that stops before the end. A period counter that is off by one changes when the level moves rather than what it moves to. The bench therefore compares the level on every cycle against a reference model, and it also runs directed runs whose tick counts land exactly on the expiry boundaries.

// File: rtl/env_pkg.sv
package env_pkg;
    localparam int LVL_W = 5;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    typedef struct packed {
        logic cont;
        logic attack;
        logic alt;
        logic hold;
    } shape_t;

    typedef struct packed {
        logic [LVL_W-1:0] step;
        logic [LVL_W-1:0] mask;
        logic             holding;
    } seq_t;
endpackage

// File: rtl/env_period_timer.sv
module env_period_timer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic              fine_we,
    input  logic              coarse_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic              expire
);
    localparam int PER_W = 2 * DATA_W;
    localparam int CNT_W = PER_W + 1;

    typedef struct packed {
        logic [PER_W-1:0] per;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        nxt_d   = cur_q;
        limit   = (cur_q.per == '0) ? CNT_W'(1) : {cur_q.per, 1'b0};
        cnt_inc = cur_q.cnt + CNT_W'(1);
        expire  = tick && !restart && (cnt_inc >= limit);
        if (restart) begin
            nxt_d.cnt = '0;
        end else if (tick) begin
            nxt_d.cnt = expire ? '0 : cnt_inc;
        end
        if (fine_we)   nxt_d.per[DATA_W-1:0]     = wr_data;
        if (coarse_we) nxt_d.per[PER_W-1:DATA_W] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    p_zero_period_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.per == '0 && tick && !restart) |-> expire);
    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cur_q.cnt == '0));
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cur_q.cnt));
endmodule

// File: rtl/env_shape_reg.sv
module env_shape_reg
    import env_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shape_we,
    input  logic [3:0] wr_shape,
    output logic       hold_eff,
    output logic       alt_eff,
    output logic       new_attack
);
    shape_t shape_q, shape_d;
    shape_t incoming;

    always_comb begin
        incoming   = shape_t'(wr_shape);
        shape_d    = shape_we ? incoming : shape_q;
        new_attack = incoming.attack;
        if (shape_q.cont) begin
            hold_eff = shape_q.hold;
            alt_eff  = shape_q.alt;
        end else begin
            hold_eff = 1'b1;
            alt_eff  = shape_q.attack;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shape_q <= '0;
        else        shape_q <= shape_d;
    end

    p_remap_no_continue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shape_we && !wr_shape[3]) |=> (hold_eff && (alt_eff == $past(wr_shape[2]))));
endmodule

// File: rtl/env_step_seq.sv
module env_step_seq
    import env_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             init_attack,
    input  logic             advance,
    input  logic             hold_eff,
    input  logic             alt_eff,
    output logic [LVL_W-1:0] level_o
);
    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (restart) begin
            nxt_d.step    = LVL_MAX;
            nxt_d.mask    = init_attack ? LVL_MAX : '0;
            nxt_d.holding = 1'b0;
        end else if (advance && !cur_q.holding) begin
            if (cur_q.step != '0) begin
                nxt_d.step = cur_q.step - 1'b1;
            end else if (hold_eff) begin
                nxt_d.holding = 1'b1;
                if (alt_eff) nxt_d.mask = ~cur_q.mask;
            end else begin
                nxt_d.step = LVL_MAX;
                if (alt_eff) nxt_d.mask = ~cur_q.mask;
            end
        end
        level_o = cur_q.step ^ cur_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.step    <= LVL_MAX;
            cur_q.mask    <= '0;
            cur_q.holding <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    p_restart_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cur_q.step == LVL_MAX && !cur_q.holding));
    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && !cur_q.holding && cur_q.step != '0)
        |=> (cur_q.step == $past(cur_q.step) - 1'b1));
    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.holding && !restart) |=> $stable(level_o));
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && !cur_q.holding && cur_q.step == '0 && !hold_eff)
        |=> (cur_q.step == LVL_MAX));
endmodule

// File: rtl/env_gen.sv
module env_gen
    import env_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fine_we,
    input  logic              coarse_we,
    input  logic              shape_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LVL_W-1:0]  level
);
    logic expire;
    logic hold_eff;
    logic alt_eff;
    logic new_attack;

    env_period_timer #(.DATA_W(DATA_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .restart   (shape_we),
        .fine_we   (fine_we),
        .coarse_we (coarse_we),
        .wr_data   (wr_data),
        .expire    (expire)
    );

    env_shape_reg u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .shape_we   (shape_we),
        .wr_shape   (wr_data[3:0]),
        .hold_eff   (hold_eff),
        .alt_eff    (alt_eff),
        .new_attack (new_attack)
    );

    env_step_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (shape_we),
        .init_attack (new_attack),
        .advance     (expire),
        .hold_eff    (hold_eff),
        .alt_eff     (alt_eff),
        .level_o     (level)
    );

    p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !shape_we) |=> $stable(level));
endmodule

// File: tb/sim_env_gen.sv
module sim_env_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       fine_we = 1'b0;
    logic       coarse_we = 1'b0;
    logic       shape_we = 1'b0;
    logic [7:0] wr_data = '0;
    logic [4:0] level;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    env_gen u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fine_we(fine_we),
        .coarse_we(coarse_we), .shape_we(shape_we), .wr_data(wr_data),
        .level(level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int m_per, m_cnt, m_step, m_mask;
    bit m_hold, m_alt, m_holding;

    function automatic int step_len(input int p);
        return (p == 0) ? 1 : 2 * p;
    endfunction

    function automatic int model_level();
        return m_step ^ m_mask;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_per = 0; m_cnt = 0; m_step = 31; m_mask = 0;
            m_hold = 1; m_alt = 0; m_holding = 0;
        end else begin
            bit fire;
            fire = tick && !shape_we && (m_cnt + 1 >= step_len(m_per));
            if (shape_we) begin
                m_cnt = 0; m_step = 31; m_holding = 0;
                m_mask = wr_data[2] ? 31 : 0;
                m_hold = wr_data[3] ? wr_data[0] : 1'b1;
                m_alt  = wr_data[3] ? wr_data[1] : wr_data[2];
            end else if (tick) begin
                m_cnt = fire ? 0 : m_cnt + 1;
            end
            if (fire && !m_holding) begin
                if (m_step > 0) m_step = m_step - 1;
                else begin
                    if (m_hold) m_holding = 1;
                    else m_step = 31;
                    if (m_alt) m_mask = m_mask ^ 31;
                end
            end
            if (fine_we)   m_per = (m_per & 32'hFF00) | int'(wr_data);
            if (coarse_we) m_per = (m_per & 32'h00FF) | (int'(wr_data) << 8);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: level actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive after negedge, compare with model at the next negedge
    task automatic cyc(input bit t, input bit f, input bit c, input bit s, input logic [7:0] d);
        tick = t; fine_we = f; coarse_we = c; shape_we = s; wr_data = d;
        @(negedge clk);
        tick = 0; fine_we = 0; coarse_we = 0; shape_we = 0;
        chk("R5 model", int'(level), model_level());
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 8'h00);
    endtask

    task automatic set_per(input int p);
        cyc(0, 1, 0, 0, p[7:0]);
        cyc(0, 0, 1, 0, p[15:8]);
    endtask

    task automatic shape(input logic [3:0] s);
        cyc(0, 0, 0, 1, {4'h0, s});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset level", int'(level), 31);

        // R2 / R5 / R7 falling sawtooth at zero period
        set_per(0);
        shape(4'h8);
        chk("R4 restart falling", int'(level), 31);
        ticks(5);  chk("R2 one tick per step", int'(level), 26);
        ticks(26); chk("R5 end of ramp", int'(level), 0);
        ticks(1);  chk("R7 sawtooth reload", int'(level), 31);

        // R3 rising sawtooth
        shape(4'hC);
        chk("R3 attack start", int'(level), 0);
        ticks(31); chk("R3 rising top", int'(level), 31);
        ticks(1);  chk("R7 rising reload", int'(level), 0);

        // R7 triangle
        shape(4'hA);
        ticks(31); chk("R7 triangle bottom", int'(level), 0);
        ticks(1);  chk("R7 triangle turn", int'(level), 0);
        ticks(1);  chk("R7 triangle rising", int'(level), 1);

        // R8 continue clear
        shape(4'h0);
        ticks(42); chk("R8 decay one-shot", int'(level), 0);
        shape(4'h4);
        ticks(31); chk("R8 attack top", int'(level), 31);
        ticks(1);  chk("R8 attack drops", int'(level), 0);
        ticks(10); chk("R8 attack stays zero", int'(level), 0);

        // R6 hold variants
        shape(4'hB);
        ticks(32); chk("R6 hold inverted", int'(level), 31);
        ticks(8);  chk("R6 hold stays", int'(level), 31);
        shape(4'hD);
        ticks(40); chk("R6 hold at max", int'(level), 31);
        shape(4'h9);
        ticks(40); chk("R6 hold at zero", int'(level), 0);
        shape(4'hF);
        ticks(32); chk("R6 rise then inverted hold", int'(level), 0);

        // R1 period length
        set_per(1);
        shape(4'h8);
        ticks(1); chk("R1 period 1 first tick", int'(level), 31);
        ticks(1); chk("R1 period 1 second tick", int'(level), 30);
        set_per(16'h0100);
        shape(4'h8);
        ticks(511); chk("R1 coarse byte before", int'(level), 31);
        ticks(1);   chk("R1 coarse byte step", int'(level), 30);

        // R10 period shrink mid-count
        set_per(10);
        shape(4'h8);
        ticks(15); chk("R10 before shrink", int'(level), 31);
        set_per(2);
        chk("R10 write no step", int'(level), 31);
        ticks(1);  chk("R10 immediate expiry", int'(level), 30);

        // R4 same-value rewrite and priority over tick
        set_per(0);
        shape(4'h8);
        ticks(10); chk("R4 pre-rewrite", int'(level), 21);
        shape(4'h8);
        chk("R4 same value restarts", int'(level), 31);
        ticks(3);
        cyc(1, 0, 0, 1, 8'h08);
        chk("R4 restart beats tick", int'(level), 31);

        // R11 no ticks
        ticks(4);
        for (int i = 0; i < 50; i++) cyc(0, 0, 0, 0, 8'h00);
        chk("R11 idle stable", int'(level), 27);

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3)       shape(4'($urandom_range(0, 15)));
            else if (r < 5)  cyc(0, 1, 0, 0, 8'($urandom_range(0, 3)));
            else if (r < 6)  cyc(0, 0, 1, 0, 8'h00);
            else             cyc(($urandom_range(0, 3) != 0), 0, 0, 0, 8'h00);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule